// File: doc/BRIEF.md
# Processor Status Word with Condition Flags

This block is the 16-bit status word of a small processor core. It stores three fields: a 3-bit interrupt priority mask, a 5-bit register-bank base, and a condition byte. The condition byte holds an interrupt-enable bit, a stack-select bit and five result flags.

Every clock cycle the block receives an operation class from the execute stage. Along with it come the result bus, the carry and overflow outputs of the ALU, the bits the shifter pushed out, and the shift distance. From these it updates the result flags. A sticky flag records whether a right shift threw away any 1 bits. An interrupt-entry strobe forces the stack-select bit to supervisor. A full-register write port lets the core load the whole word at once.

The decoded interrupt-enable and stack-select bits are driven out directly from the register. Interrupt arbitration and the stack pointers live in neighbouring blocks and use these two outputs.

Top module: `status_word_reg`

## Requirements
- R1: The layout of `psw` is fixed: bits 15..13 are the interrupt mask, bits 12..8 are the bank base, and bits 7..0 are the condition byte. Within the condition byte, bit 6 is I, bit 5 is S, bit 4 is T, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. Bit 7 always reads 0.
- R2: A synchronous reset (`rst` high at a clock edge) sets `psw` to 0x0020: S is 1 and every other bit is 0. After reset, `int_en` is 0 and `sup_stack` is 1.
- R3: `int_en` equals the I bit: 1 enables hardware interrupt requests and 0 masks them.
- R4: `sup_stack` equals the S bit. A high `int_entry` at a clock edge makes S equal 1 after that edge. The strobe changes no other bit.
- R5: A high `wr_en` at a clock edge loads `wr_data` into `psw`, with bit 7 cleared. This write overrides any flag update in the same cycle. Only S is still forced to 1 if `int_entry` is also high.
- R6: The `op_class` encoding is 0 = other, 1 = arithmetic, 2 = logical right shift and 3 = arithmetic right shift. For classes 1 to 3, N takes the MSB of `result`, and Z is 1 only when every bit of `result` is 0.
- R7: For classes 1 to 3, V takes `alu_ovf` and C takes `alu_carry`.
- R8: For classes 2 and 3, T becomes 1 if `shift_cnt` is nonzero and any bit of `shift_lost` is 1. Otherwise T becomes 0, and it is always 0 when `shift_cnt` is 0.
- R9: Classes 0 and 1 clear T. Class 0 leaves N, Z, V and C unchanged.
- R10: Flag updates never change the interrupt mask, the bank base, I or S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | Operation class of the current result |
| result | input | DW | Result bus from the datapath |
| alu_carry | input | 1 | Carry or borrow out of the MSB |
| alu_ovf | input | 1 | Signed overflow indication |
| shift_lost | input | DW | Bits shifted out by a right shift; unused positions are 0 |
| shift_cnt | input | CW | Shift distance in places |
| int_entry | input | 1 | Interrupt entry strobe |
| wr_en | input | 1 | Full-register write enable |
| wr_data | input | 16 | Full-register write value |
| psw | output | 16 | Status word |
| int_en | output | 1 | Interrupt enable (I bit) |
| sup_stack | output | 1 | Supervisor stack select (S bit) |

## Verification
The hardest situations to reach from the ports are those where several update sources meet in one cycle. One case is a full write at the same edge as a flag-producing operation. Another is a write that clears S at the same edge as an interrupt entry. A third is a right shift whose lost bits are nonzero while its count is zero. The bench first walks a vector table that strings operations together, so that the hold-versus-clear behaviour of the "other" class is seen after sticky and flag-setting steps. It then drives these collisions directly and checks the fields that the flag logic must leave untouched.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned PSW_W  = 16;
  localparam int unsigned B_C    = 0;
  localparam int unsigned B_V    = 1;
  localparam int unsigned B_Z    = 2;
  localparam int unsigned B_N    = 3;
  localparam int unsigned B_T    = 4;
  localparam int unsigned B_S    = 5;
  localparam int unsigned B_I    = 6;
  localparam int unsigned B_RSV  = 7;
  localparam logic [PSW_W-1:0] PSW_RESET = 16'h0020;

  typedef enum logic [1:0] {
    OPC_OTHER = 2'd0,
    OPC_ARITH = 2'd1,
    OPC_LSR   = 2'd2,
    OPC_ASR   = 2'd3
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } res_flags_t;
endpackage

// File: rtl/psw_result_flags.sv
module psw_result_flags #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]        result,
  input  logic                 alu_carry,
  input  logic                 alu_ovf,
  output psw_pkg::res_flags_t  flags
);
  always_comb begin
    flags.n = result[DW-1];
    flags.z = (result == '0);
    flags.v = alu_ovf;
    flags.c = alu_carry;
  end
endmodule

// File: rtl/psw_sticky_eval.sv
module psw_sticky_eval #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = $clog2(DW) + 1
) (
  input  psw_pkg::op_class_e op,
  input  logic [DW-1:0]      shift_lost,
  input  logic [CW-1:0]      shift_cnt,
  output logic               sticky
);
  logic is_rshift;
  logic any_lost;

  assign is_rshift = (op == psw_pkg::OPC_LSR) || (op == psw_pkg::OPC_ASR);
  assign any_lost  = |shift_lost;
  assign sticky    = is_rshift && (shift_cnt != '0) && any_lost;
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = $clog2(DW) + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 op_class,
  input  logic [DW-1:0]              result,
  input  logic                       alu_carry,
  input  logic                       alu_ovf,
  input  logic [DW-1:0]              shift_lost,
  input  logic [CW-1:0]              shift_cnt,
  input  logic                       int_entry,
  input  logic                       wr_en,
  input  logic [psw_pkg::PSW_W-1:0]  wr_data,
  output logic [psw_pkg::PSW_W-1:0]  psw,
  output logic                       int_en,
  output logic                       sup_stack
);
  import psw_pkg::*;

  op_class_e  op;
  res_flags_t rf;
  logic       t_next;
  logic       upd_nzvc;
  logic [PSW_W-1:0] psw_q;

  assign op       = op_class_e'(op_class);
  assign upd_nzvc = (op != OPC_OTHER);

  psw_result_flags #(.DW(DW)) u_rflags (
    .result    (result),
    .alu_carry (alu_carry),
    .alu_ovf   (alu_ovf),
    .flags     (rf)
  );

  psw_sticky_eval #(.DW(DW), .CW(CW)) u_sticky (
    .op         (op),
    .shift_lost (shift_lost),
    .shift_cnt  (shift_cnt),
    .sticky     (t_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q <= PSW_RESET;
    end else begin
      if (wr_en) begin
        psw_q        <= wr_data;
        psw_q[B_RSV] <= 1'b0;
      end else begin
        if (upd_nzvc) begin
          psw_q[B_N] <= rf.n;
          psw_q[B_Z] <= rf.z;
          psw_q[B_V] <= rf.v;
          psw_q[B_C] <= rf.c;
        end
        psw_q[B_T] <= t_next;
      end
      if (int_entry) psw_q[B_S] <= 1'b1;
    end
  end

  assign psw       = psw_q;
  assign int_en    = psw_q[B_I];
  assign sup_stack = psw_q[B_S];
endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = $clog2(DW) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    op_class,
  input logic          int_entry,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic [CW-1:0] shift_cnt,
  input logic [15:0]   psw,
  input logic          int_en,
  input logic          sup_stack
);
  // R2
  a_r2_reset_value: assert property (@(posedge clk) rst |=> (psw == 16'h0020));
  // R1
  a_r1_rsv_zero: assert property (@(posedge clk) disable iff (rst) !rst |=> !psw[7]);
  // R4
  a_r4_entry_super: assert property (@(posedge clk) disable iff (rst) int_entry |=> sup_stack);
  // R5
  a_r5_write_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !int_entry) |=> (psw == ($past(wr_data) & 16'hFF7F)));
  // R3
  a_r3_ie_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (int_en == $past(wr_data[6])));
  // R9
  a_r9_other_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && op_class == 2'd0) |=> (!psw[4] && psw[3:0] == $past(psw[3:0])));
  // R8
  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && op_class[1] && shift_cnt == '0) |=> !psw[4]);
  // R10
  a_r10_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !int_entry) |=> $stable(psw[15:5]));
endmodule

bind status_word_reg psw_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_class  (op_class),
  .int_entry (int_entry),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .shift_cnt (shift_cnt),
  .psw       (psw),
  .int_en    (int_en),
  .sup_stack (sup_stack)
);

// File: tb/sim_status_word_reg.sv
`timescale 1ns/1ps
module sim_status_word_reg;
  localparam int unsigned DW = 16;
  localparam int unsigned CW = 5;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] op_class;
  logic [DW-1:0] result, shift_lost;
  logic alu_carry, alu_ovf, int_entry, wr_en;
  logic [CW-1:0] shift_cnt;
  logic [15:0] wr_data, psw;
  logic int_en, sup_stack;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  status_word_reg #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .op_class(op_class), .result(result),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .shift_lost(shift_lost),
    .shift_cnt(shift_cnt), .int_entry(int_entry), .wr_en(wr_en),
    .wr_data(wr_data), .psw(psw), .int_en(int_en), .sup_stack(sup_stack)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] res;
    logic        cy;
    logic        ov;
    logic [15:0] lost;
    logic [4:0]  cnt;
    logic [4:0]  exp_tnzvc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'h0000, 1'b1, 1'b0, 16'h0000, 5'd0,  5'b00101},
    '{2'd1, 16'h8001, 1'b0, 1'b1, 16'h0000, 5'd0,  5'b01010},
    '{2'd0, 16'h0000, 1'b1, 1'b1, 16'hFFFF, 5'd3,  5'b01010},
    '{2'd2, 16'h4000, 1'b1, 1'b0, 16'h0001, 5'd1,  5'b10001},
    '{2'd3, 16'hC000, 1'b0, 1'b0, 16'h0000, 5'd2,  5'b01000},
    '{2'd3, 16'hFFFF, 1'b1, 1'b0, 16'h0006, 5'd3,  5'b11001},
    '{2'd2, 16'h0000, 1'b0, 1'b0, 16'h0004, 5'd0,  5'b00100},
    '{2'd2, 16'h0001, 1'b0, 1'b0, 16'h8000, 5'd15, 5'b10000},
    '{2'd1, 16'h7FFF, 1'b0, 1'b0, 16'h0000, 5'd0,  5'b00000}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    op_class = 2'd0; result = '0; alu_carry = 0; alu_ovf = 0;
    shift_lost = '0; shift_cnt = '0; int_entry = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    step();
    chk("R2 reset psw", psw, 16'h0020);
    chk("R2 reset int_en/sup_stack", {14'd0, int_en, sup_stack}, 16'h0001);
    rst = 0;

    // vector table: flag updates from result, carry, overflow, sticky
    for (int i = 0; i < NV; i++) begin
      op_class = VECS[i].op; result = VECS[i].res; alu_carry = VECS[i].cy;
      alu_ovf = VECS[i].ov; shift_lost = VECS[i].lost; shift_cnt = VECS[i].cnt;
      step();
      chk($sformatf("R6 R7 R8 R9 vec%0d flags", i), {11'd0, psw[4:0]}, {11'd0, VECS[i].exp_tnzvc});
      chk($sformatf("R10 vec%0d upper", i), {5'd0, psw[15:5]}, 16'h0001);
    end
    idle();

    // R5, R1: full write, bit 7 reads 0, R3 decode
    wr_en = 1; wr_data = 16'hFFFF; step();
    chk("R5 R1 write all ones", psw, 16'hFF7F);
    chk("R3 int_en set", {15'd0, int_en}, 16'h0001);

    // R5: write wins over simultaneous arithmetic op
    wr_en = 1; wr_data = 16'h1F40; op_class = 2'd1; result = 16'h0000; alu_carry = 1; alu_ovf = 1;
    step();
    chk("R5 write beats flags", psw, 16'h1F40);
    chk("R4 sup_stack clear after write", {15'd0, sup_stack}, 16'h0000);
    idle();

    // R4: interrupt entry alone sets only S
    int_entry = 1; step();
    chk("R4 entry sets S", psw, 16'h1F60);
    idle();

    // R5 + R4: write clearing S with entry in same cycle
    wr_en = 1; wr_data = 16'h0000; int_entry = 1; step();
    chk("R5 R4 write with entry", psw, 16'h0020);
    idle();

    // R3: I cleared masks
    chk("R3 int_en clear", {15'd0, int_en}, 16'h0000);

    // R10: flag update keeps mask, bank, I, S
    wr_en = 1; wr_data = 16'hE3C0; step();
    chk("R5 R1 write E3C0", psw, 16'hE340);
    idle();
    op_class = 2'd1; result = 16'h0000; step();
    chk("R10 R6 arith keeps upper", psw, 16'hE344);

    // R8 then R9: sticky set, then other class clears T and holds NZVC
    op_class = 2'd3; result = 16'h8000; shift_lost = 16'h0010; shift_cnt = 5'd4; alu_carry = 1; step();
    chk("R8 R6 asr sticky", psw, 16'hE359);
    idle(); step();
    chk("R9 other clears T holds NZVC", psw, 16'hE349);

    // R9: arithmetic clears T
    op_class = 2'd2; result = 16'h0002; shift_lost = 16'h0001; shift_cnt = 5'd1; step();
    chk("R8 lsr sticky", psw, 16'hE350);
    idle(); op_class = 2'd1; result = 16'h0002; step();
    chk("R9 arith clears T", psw, 16'hE340);
    idle();

    // R2: reset mid-run
    rst = 1; step(); rst = 0;
    chk("R2 reset mid-run", psw, 16'h0020);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule